// File: doc/BRIEF.md
# Exception Cause and Reset-Status Register Block

This block keeps the processor's exception Cause word together with the Status register of the same core. When the pipeline pulses its exception strobe, the block stores the exception code, the delay-slot flag and the coprocessor number in that same clock edge. It samples the timer line and the ordinary interrupt lines into the pending field on every clock. Software can change only the two software-interrupt pending bits.

The Status register is a plain masked read/write register, except for the bits that reset touches. A cold reset sets it to a known value with boot-vector select and error level set. A soft reset or an NMI sets the soft-reset flag and error level and changes nothing else. Software reads either register through one registered read port. It writes through a port that has a per-bit write mask. A registered interrupt request goes high when an enabled pending bit is set, the global enable is 1 and error level is 0.

Top module: `trap_regs`

## Requirements
- R1: A cold reset (`rst` high at a clock edge) sets Status to 0x0040_0004: bit 22 (boot vector) = 1, bit 2 (error level) = 1, bit 21 = 0, bit 20 (soft-reset flag) = 0, all other bits 0. It clears every stored Cause field.
- R2: A pulse on `soft_rst_i` or `nmi_i` sets Status bits 20 and 2 to 1 and wins over a write to those bits in the same cycle. It leaves the other Status bits and all stored Cause fields unchanged.
- R3: An `exc_strobe_i` pulse loads Cause[6:2] from `exc_code_i`, Cause[31] from `exc_bd_i` and Cause[29:28] from `exc_ce_i` at the same edge. A later strobe replaces all three fields.
- R4: A Cause write (`wr_sel_i`=1) changes only Cause[9:8], the software pending bits, and only where `wr_mask_i` is 1. Every other Cause bit ignores the write.
- R5: Cause bits 30, 27:16, 7 and 1:0 always read 0.
- R6: Cause[15] follows `timer_irq_i` and Cause[14:10] follow `hw_irq_i[4:0]`, each one clock after the line is sampled.
- R7: `irq_o` is 1 exactly when (Cause[15:8] & Status[15:8]) is nonzero, Status[0] = 1 and Status[2] = 0, as judged on the register state one clock earlier.
- R8: A Status write (`wr_sel_i`=0) replaces exactly the bits where `wr_mask_i` is 1.
- R9: An exception strobe and a Cause write in the same cycle both take effect.
- R10: `rd_data_o` shows Status when `rd_sel_i`=0 and Cause when `rd_sel_i`=1, as sampled at a clock edge. It changes only at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| soft_rst_i | input | 1 | Soft reset pulse |
| nmi_i | input | 1 | Non-maskable interrupt pulse |
| exc_strobe_i | input | 1 | Exception taken this cycle |
| exc_code_i | input | 5 | Exception code to record |
| exc_bd_i | input | 1 | Exception was in a branch delay slot |
| exc_ce_i | input | 2 | Coprocessor number for an unusable-coprocessor fault |
| timer_irq_i | input | 1 | Timer interrupt line |
| hw_irq_i | input | 5 | Ordinary interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 Status, 1 Cause |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 32 | Per-bit write enable |
| rd_sel_i | input | 1 | Read target: 0 Status, 1 Cause |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every stored field can be read back through the read port two edges after it is stimulated, so a wrong capture, a missing reset value or a stray write shows up as a wrong word within two cycles. A wrong pending sample or a wrong mask term appears on `irq_o` with the same two-cycle delay. The same delay applies when the enable or error-level gating is wrong. Priority faults are driven on purpose: a soft reset collides with a write to the same bits, and a strobe collides with a software write.

// File: rtl/trap_regs_pkg.sv
package trap_regs_pkg;
  localparam int REG_W    = 32;
  // Cause layout
  localparam int BD_BIT   = 31;
  localparam int CE_LO    = 28;
  localparam int CE_W     = 2;
  localparam int IP_LO    = 8;
  localparam int CODE_LO  = 2;
  localparam int CODE_W   = 5;
  // Status layout
  localparam int ST_BEV   = 22;
  localparam int ST_TS    = 21;
  localparam int ST_SR    = 20;
  localparam int ST_ERL   = 2;
  localparam int ST_IE    = 0;
  localparam int ST_IM_LO = 8;

  localparam logic [REG_W-1:0] CAUSE_ZERO_BITS = 32'h4FFF_0083;
  localparam logic [REG_W-1:0] STATUS_COLD     =
    (REG_W'(1) << ST_BEV) | (REG_W'(1) << ST_ERL);

  typedef enum logic {SEL_STATUS = 1'b0, SEL_CAUSE = 1'b1} reg_sel_e;
endpackage

// File: rtl/trap_status_core.sv
module trap_status_core
  import trap_regs_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reinit_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] wr_mask_i,
  output logic [W-1:0] status_q
);
  logic [W-1:0] status_nxt;

  always_comb begin
    status_nxt = status_q;
    if (wr_en_i)
      status_nxt = (status_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    // soft reset / NMI override any same-cycle write of these two bits
    if (reinit_i) begin
      status_nxt[ST_SR]  = 1'b1;
      status_nxt[ST_ERL] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= W'(STATUS_COLD);
    else     status_q <= status_nxt;
  end
endmodule

// File: rtl/trap_cause_capture.sv
module trap_cause_capture
  import trap_regs_pkg::*;
#(
  parameter int SW_N  = 2,
  parameter int CODEW = CODE_W,
  parameter int CEW   = CE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [CODEW-1:0] code_i,
  input  logic             bd_i,
  input  logic [CEW-1:0]   ce_i,
  input  logic             sw_wr_i,
  input  logic [SW_N-1:0]  sw_data_i,
  input  logic [SW_N-1:0]  sw_mask_i,
  output logic [SW_N-1:0]  sw_ip_q,
  output logic [CODEW-1:0] code_q,
  output logic             bd_q,
  output logic [CEW-1:0]   ce_q
);
  logic [SW_N-1:0] sw_nxt;

  always_comb begin
    sw_nxt = sw_ip_q;
    if (sw_wr_i) sw_nxt = (sw_ip_q & ~sw_mask_i) | (sw_data_i & sw_mask_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_ip_q <= '0;
      code_q  <= '0;
      bd_q    <= 1'b0;
      ce_q    <= '0;
    end else begin
      sw_ip_q <= sw_nxt;
      if (strobe_i) begin
        code_q <= code_i;
        bd_q   <= bd_i;
        ce_q   <= ce_i;
      end
    end
  end
endmodule

// File: rtl/trap_irq_sampler.sv
module trap_irq_sampler #(
  parameter int HW_N = 5,
  parameter int SW_N = 2,
  localparam int IP_N = HW_N + SW_N + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            timer_i,
  input  logic [HW_N-1:0] hw_i,
  input  logic [SW_N-1:0] sw_ip_i,
  input  logic [IP_N-1:0] im_i,
  input  logic            ie_i,
  input  logic            erl_i,
  output logic [IP_N-1:0] ip_o,
  output logic            irq_q
);
  logic [HW_N:0]   line_q;
  logic [IP_N-1:0] hit;

  assign ip_o = {line_q, sw_ip_i};

  for (genvar i = 0; i < IP_N; i++) begin : g_hit
    assign hit[i] = ip_o[i] & im_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      line_q <= {timer_i, hw_i};
      irq_q  <= (|hit) & ie_i & ~erl_i;
    end
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_regs_pkg::*;
#(
  parameter int HW_IRQ_N = 5,
  parameter int SW_IRQ_N = 2,
  localparam int IP_N    = HW_IRQ_N + SW_IRQ_N + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_i,
  input  logic              nmi_i,
  input  logic              exc_strobe_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              exc_bd_i,
  input  logic [CE_W-1:0]   exc_ce_i,
  input  logic              timer_irq_i,
  input  logic [HW_IRQ_N-1:0] hw_irq_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [REG_W-1:0]  wr_mask_i,
  input  logic              rd_sel_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic [REG_W-1:0]    status_q;
  logic [REG_W-1:0]    cause_word;
  logic [SW_IRQ_N-1:0] sw_ip;
  logic [CODE_W-1:0]   code_q;
  logic                bd_q;
  logic [CE_W-1:0]     ce_q;
  logic [IP_N-1:0]     ip;
  reg_sel_e            rsel;
  reg_sel_e            wsel;

  assign rsel = reg_sel_e'(rd_sel_i);
  assign wsel = reg_sel_e'(wr_sel_i);

  trap_status_core #(.W(REG_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .reinit_i  (soft_rst_i | nmi_i),
    .wr_en_i   (wr_en_i && wsel == SEL_STATUS),
    .wr_data_i (wr_data_i),
    .wr_mask_i (wr_mask_i),
    .status_q  (status_q)
  );

  trap_cause_capture #(.SW_N(SW_IRQ_N), .CODEW(CODE_W), .CEW(CE_W)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .strobe_i  (exc_strobe_i),
    .code_i    (exc_code_i),
    .bd_i      (exc_bd_i),
    .ce_i      (exc_ce_i),
    .sw_wr_i   (wr_en_i && wsel == SEL_CAUSE),
    .sw_data_i (wr_data_i[IP_LO +: SW_IRQ_N]),
    .sw_mask_i (wr_mask_i[IP_LO +: SW_IRQ_N]),
    .sw_ip_q   (sw_ip),
    .code_q    (code_q),
    .bd_q      (bd_q),
    .ce_q      (ce_q)
  );

  trap_irq_sampler #(.HW_N(HW_IRQ_N), .SW_N(SW_IRQ_N)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .timer_i (timer_irq_i),
    .hw_i    (hw_irq_i),
    .sw_ip_i (sw_ip),
    .im_i    (status_q[ST_IM_LO +: IP_N]),
    .ie_i    (status_q[ST_IE]),
    .erl_i   (status_q[ST_ERL]),
    .ip_o    (ip),
    .irq_q   (irq_o)
  );

  always_comb begin
    cause_word = '0;
    cause_word[BD_BIT]            = bd_q;
    cause_word[CE_LO +: CE_W]     = ce_q;
    cause_word[IP_LO +: IP_N]     = ip;
    cause_word[CODE_LO +: CODE_W] = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                    rd_data_o <= '0;
    else if (rsel == SEL_CAUSE) rd_data_o <= cause_word;
    else                        rd_data_o <= status_q;
  end
endmodule

// File: rtl/trap_regs_chk.sv
module trap_regs_chk
  import trap_regs_pkg::*;
#(
  parameter int HW_N = 5,
  parameter int SW_N = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst_i,
  input logic              nmi_i,
  input logic              exc_strobe_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic              exc_bd_i,
  input logic [CE_W-1:0]   exc_ce_i,
  input logic              timer_irq_i,
  input logic [HW_N-1:0]   hw_irq_i,
  input logic              rd_sel_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  status_q,
  input logic [REG_W-1:0]  cause_word
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  assert_cold_values_R1: assert property (@(posedge clk) disable iff (rst)
    (started && $past(rst)) |->
      (status_q[ST_BEV] && status_q[ST_ERL] && !status_q[ST_TS] && !status_q[ST_SR]));

  assert_reinit_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(soft_rst_i || nmi_i)) |->
      (status_q[ST_SR] && status_q[ST_ERL]));

  assert_reinit_keeps_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(soft_rst_i || nmi_i) && !$past(exc_strobe_i)) |->
      (cause_word[31:28] == $past(cause_word[31:28]) && cause_word[6:2] == $past(cause_word[6:2])));

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(exc_strobe_i)) |->
      (cause_word[CODE_LO +: CODE_W] == $past(exc_code_i) &&
       cause_word[BD_BIT] == $past(exc_bd_i) &&
       cause_word[CE_LO +: CE_W] == $past(exc_ce_i)));

  assert_zero_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(rd_sel_i)) |-> ((rd_data_o & CAUSE_ZERO_BITS) == '0));

  assert_lines_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |->
      (cause_word[IP_LO + SW_N +: HW_N + 1] == $past({timer_irq_i, hw_irq_i})));

  assert_irq_rule_R7: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |->
      (irq_o == $past((|(cause_word[15:8] & status_q[15:8])) && status_q[ST_IE] && !status_q[ST_ERL])));

  assert_read_status_R10: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && !$past(rd_sel_i)) |-> (rd_data_o == $past(status_q)));

  assert_read_cause_R10: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(rd_sel_i)) |-> (rd_data_o == $past(cause_word)));
endmodule

bind trap_regs trap_regs_chk #(.HW_N(HW_IRQ_N), .SW_N(SW_IRQ_N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .soft_rst_i   (soft_rst_i),
  .nmi_i        (nmi_i),
  .exc_strobe_i (exc_strobe_i),
  .exc_code_i   (exc_code_i),
  .exc_bd_i     (exc_bd_i),
  .exc_ce_i     (exc_ce_i),
  .timer_irq_i  (timer_irq_i),
  .hw_irq_i     (hw_irq_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .irq_o        (irq_o),
  .status_q     (status_q),
  .cause_word   (cause_word)
);

// File: tb/trap_regs_test.sv
module trap_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst_i = 0, nmi_i = 0, exc_strobe_i = 0;
  logic [4:0]  exc_code_i = '0;
  logic        exc_bd_i = 0;
  logic [1:0]  exc_ce_i = '0;
  logic        timer_irq_i = 0;
  logic [4:0]  hw_irq_i = '0;
  logic        wr_en_i = 0, wr_sel_i = 0, rd_sel_i = 0;
  logic [31:0] wr_data_i = '0, wr_mask_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trap_regs uut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic rd(input logic sel, output logic [31:0] val);
    rd_sel_i = sel;
    @(negedge clk);
    val = rd_data_o;
  endtask

  task automatic rd_chk(input string req, input logic sel, input logic [31:0] exp);
    logic [31:0] v;
    rd(sel, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input logic [31:0] m);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d; wr_mask_i = m;
    @(negedge clk);
    wr_en_i = 0; wr_data_i = '0; wr_mask_i = '0;
  endtask

  task automatic exc(input logic [4:0] code, input logic bd, input logic [1:0] ce);
    exc_strobe_i = 1; exc_code_i = code; exc_bd_i = bd; exc_ce_i = ce;
    @(negedge clk);
    exc_strobe_i = 0;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    chk(req, {31'b0, irq_o}, {31'b0, exp});
  endtask

  task automatic t_cold_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    rd_chk("R1 status", 0, 32'h0040_0004);
    rd_chk("R1 cause", 1, 32'h0000_0000);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_status_write();
    wr(0, 32'hFFFF_FFFF, 32'h0000_FF01);
    rd_chk("R8 set IM/IE", 0, 32'h0040_FF05);
    wr(0, 32'h0000_0000, 32'h0000_0004);
    rd_chk("R8 clear ERL only", 0, 32'h0040_FF01);
  endtask

  task automatic t_exception();
    exc(5'd5, 1'b1, 2'd2);
    rd_chk("R3 capture", 1, 32'hA000_0014);
    exc(5'd12, 1'b0, 2'd0);
    rd_chk("R3 replace", 1, 32'h0000_0030);
  endtask

  task automatic t_cause_write();
    wr(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_chk("R4 R5 all-ones write", 1, 32'h0000_0330);
    wr(1, 32'h0000_0000, 32'h0000_0100);
    rd_chk("R4 masked clear IP0", 1, 32'h0000_0230);
  endtask

  task automatic t_soft_and_nmi();
    soft_rst_i = 1; @(negedge clk); soft_rst_i = 0;
    rd_chk("R2 soft status", 0, 32'h0050_FF05);
    rd_chk("R2 soft cause", 1, 32'h0000_0230);
    wr(0, 32'h0, 32'h0010_0004);
    rd_chk("R8 clear SR ERL", 0, 32'h0040_FF01);
    nmi_i = 1; @(negedge clk); nmi_i = 0;
    rd_chk("R2 nmi status", 0, 32'h0050_FF05);
    // write of the same bits in the reinit cycle loses
    wr(0, 32'h0, 32'h0010_0004);
    wr_en_i = 1; wr_sel_i = 0; wr_data_i = 32'h0; wr_mask_i = 32'h0010_0004; soft_rst_i = 1;
    @(negedge clk);
    wr_en_i = 0; wr_mask_i = '0; soft_rst_i = 0;
    rd_chk("R2 priority over write", 0, 32'h0050_FF05);
    wr(0, 32'h0, 32'h0010_0004);
    rd_chk("R8 restore", 0, 32'h0040_FF01);
  endtask

  task automatic t_read_latency();
    logic [31:0] v;
    rd(0, v);
    rd_sel_i = 1;
    #1;
    chk("R10 held until edge", rd_data_o, 32'h0040_FF01);
    @(negedge clk);
    chk("R10 cause after edge", rd_data_o, 32'h0000_0230);
  endtask

  task automatic t_hw_lines();
    timer_irq_i = 1; hw_irq_i = 5'b10101;
    @(negedge clk);
    rd_chk("R6 lines", 1, 32'h0000_D630);
    timer_irq_i = 0; hw_irq_i = 5'b00000;
    @(negedge clk);
    rd_chk("R6 lines low", 1, 32'h0000_0230);
  endtask

  task automatic t_irq();
    irq_chk("R7 sw pending enabled", 1'b1);
    wr(0, 32'h0, 32'h0000_FF00);
    irq_chk("R7 all masked", 1'b0);
    wr(0, 32'h0000_0400, 32'h0000_FF00);
    irq_chk("R7 IP2 enabled, idle", 1'b0);
    hw_irq_i = 5'b00001;
    @(negedge clk);
    irq_chk("R7 hw line raises", 1'b1);
    wr(0, 32'h4, 32'h4);
    irq_chk("R7 ERL blocks", 1'b0);
    wr(0, 32'h0, 32'h4);
    irq_chk("R7 ERL cleared", 1'b1);
    wr(0, 32'h0, 32'h1);
    irq_chk("R7 IE blocks", 1'b0);
    hw_irq_i = '0;
    wr(0, 32'h0000_FF01, 32'h0000_FF01);
  endtask

  task automatic t_simultaneous();
    exc_strobe_i = 1; exc_code_i = 5'h1F; exc_bd_i = 0; exc_ce_i = 2'd1;
    wr_en_i = 1; wr_sel_i = 1; wr_data_i = 32'h0000_0100; wr_mask_i = 32'h0000_0300;
    @(negedge clk);
    exc_strobe_i = 0; wr_en_i = 0; wr_mask_i = '0;
    rd_chk("R9 strobe plus write", 1, 32'h1000_017C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_cold_reset();
    t_status_write();
    t_exception();
    t_cause_write();
    t_soft_and_nmi();
    t_read_latency();
    t_hw_lines();
    t_irq();
    t_simultaneous();
    t_cold_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule